// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block is a synchronous state machine. It moves a processor platform through four steady power states: mechanical off (G3), soft off (S5), suspend-to-RAM (S3) and fully on (S0). Between the steady states it passes through short transition states. Each transition drives rail enables and handshake lines in a fixed order. It waits a parameterized number of clock cycles wherever a settling delay is required. It also bounds every wait for a rail-good signal with a parameterized timeout.

The platform controller asks for state changes through two active-low sleep requests, one for S3 and one for S5. A request line that reads high means "stay awake at this level". Both request lines are asynchronous and pass through two-flop synchronizers. The rail power-good inputs are sampled directly.

If a required rail drops while the platform sits in S3 or S0, the block performs a forced shutdown. It drops deep-power-ok and asserts the resume reset. That condition stays latched, so the machine walks the platform down to G3 and then starts a fresh power-up from the always-on rail. If a rail-good wait times out, the block falls back to the state it came from. The suspend-acknowledge output mirrors the suspend-warning input. The throttle line follows the throttle request only while the platform is fully on.

Top module: `pwrseq_fsm`

## Requirements
- R1: During and right after reset, all enables, the power-ok lines and the throttle line are low. The resume, lightbar and touchscreen resets are asserted (low).
- R2: From G3 with the always-on rail good, deep-power-ok and resume_rst_n rise together DSW_CYC+2 cycles later. S5 is entered SUS_CYC+1 cycles after that. deep_pwr_ok always equals resume_rst_n.
- R3: In S5, a high synchronized S5 request releases the lightbar reset and enables the memory rail, once the always-on rail is good. After mem-good is seen, touchpad power turns on and S3 is entered.
- R4: If always-on good or mem-good does not arrive within RAIL_TMO cycles during S5→S3, a forced shutdown occurs. The memory rail and lightbar reset are withdrawn, and the machine returns to S5.
- R5: In S3, a high synchronized S3 request enables the switched rails and wireless, and releases the touchscreen reset. When all NONCORE_N non-core rails are good, the core rails enable. CORE_CYC+1 cycles later, plat_pwr_ok rises.
- R6: If the non-core rails are not all good within RAIL_TMO cycles, the block forces a shutdown. It returns to S3 with the touchscreen in reset and the switched rails and wireless off.
- R7: In S0, a low S3 request drops plat_pwr_ok first, while the core rails stay on. OFF_CYC+1 cycles later, the core rails, wireless, throttle and switched rails all turn off in the same cycle.
- R8: Loss of any required rail in S3 or S0 forces a shutdown. Rail loss takes priority over a sleep request seen in the same cycle. The latched shutdown then walks the platform to G3, which turns the memory rail off.
- R9: While the platform is in S3, touchscreen_rst_n follows lid_open one cycle later.
- R10: While in S0, cpu_throttle follows throttle_req one cycle later. On entry to S0 it loads the stored request. Outside S0 it stays low.
- R11: sus_ack_n equals sus_warn_n at all times.
- R12: Enables are nested: plat_pwr_ok implies en_core, en_core implies en_switched, and en_switched implies en_mem.
- R13: In S5, loss of the always-on rail drops deep-power-ok and asserts the resume reset via S5→G3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_always_on | input | 1 | Always-on rail good |
| pg_mem | input | 1 | Memory rail good |
| pg_noncore | input | NONCORE_N | Non-core rails good, one bit per rail |
| sleep_s3_n | input | 1 | Active-low S3 request (asynchronous) |
| sleep_s5_n | input | 1 | Active-low S5 request (asynchronous) |
| lid_open | input | 1 | Lid open |
| throttle_req | input | 1 | Processor throttle request |
| sus_warn_n | input | 1 | Suspend warning |
| en_mem | output | 1 | Memory rail enable |
| en_switched | output | 1 | Switched rails enable |
| en_core | output | 1 | Core regulators enable |
| en_touchpad | output | 1 | Touchpad power enable |
| wireless_en | output | 1 | Wireless enable |
| lightbar_rst_n | output | 1 | Lightbar reset, active low |
| touchscreen_rst_n | output | 1 | Touchscreen reset, active low |
| plat_pwr_ok | output | 1 | Platform power ok |
| deep_pwr_ok | output | 1 | Deep power ok |
| resume_rst_n | output | 1 | Resume reset, active low |
| cpu_throttle | output | 1 | Processor hot / throttle line |
| sus_ack_n | output | 1 | Suspend acknowledge |

## Verification
A falling S3 request and a drop of a non-core rail can reach the state machine in the same S0 cycle. The sleep path is two flops longer than the rail path. So the bench lowers the request first and drops a rail exactly two cycles later, which makes both arrive together. The outcome is judged by deep_pwr_ok. A correct priority takes the forced path and deep_pwr_ok falls together with plat_pwr_ok. Serving the sleep request first would leave deep_pwr_ok high through the whole power-down.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_G3,
    ST_G3S5_DLY,
    ST_G3S5_SUS,
    ST_S5,
    ST_S5S3_AO,
    ST_S5S3_MEM,
    ST_S3,
    ST_S3S0_NC,
    ST_S3S0_DLY,
    ST_S0,
    ST_S0S3,
    ST_S3S5,
    ST_S5G3
  } pwr_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ff1 <= 1'b0;
        ff2 <= 1'b0;
      end else begin
        ff1 <= d_async[i];
        ff2 <= ff1;
      end
    end
    assign q_sync[i] = ff2;
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned NONCORE_N = 3,
  parameter int unsigned DSW_CYC   = 1000,
  parameter int unsigned SUS_CYC   = 500,
  parameter int unsigned CORE_CYC  = 9900,
  parameter int unsigned OFF_CYC   = 100,
  parameter int unsigned RAIL_TMO  = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pg_always_on,
  input  logic                 pg_mem,
  input  logic [NONCORE_N-1:0] pg_noncore,
  input  logic                 sleep_s3_n,
  input  logic                 sleep_s5_n,
  input  logic                 lid_open,
  input  logic                 throttle_req,
  input  logic                 sus_warn_n,
  output logic                 en_mem,
  output logic                 en_switched,
  output logic                 en_core,
  output logic                 en_touchpad,
  output logic                 wireless_en,
  output logic                 lightbar_rst_n,
  output logic                 touchscreen_rst_n,
  output logic                 plat_pwr_ok,
  output logic                 deep_pwr_ok,
  output logic                 resume_rst_n,
  output logic                 cpu_throttle,
  output logic                 sus_ack_n
);
  localparam int unsigned MAX_WAIT = umax(umax(umax(DSW_CYC, SUS_CYC), umax(CORE_CYC, OFF_CYC)), RAIL_TMO);
  localparam int unsigned TW       = $clog2(MAX_WAIT + 1);

  pwr_state_e    state, state_nx;
  logic          force_off;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic [1:0]    req_sync;
  logic          s3_awake, s5_awake;
  logic          rails_s3, rails_s0;

  pwrseq_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({sleep_s3_n, sleep_s5_n}),
    .q_sync (req_sync)
  );
  assign s3_awake = req_sync[1];
  assign s5_awake = req_sync[0];

  pwrseq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_done)
  );

  assign rails_s3 = pg_always_on & pg_mem;
  assign rails_s0 = rails_s3 & (&pg_noncore);
  assign sus_ack_n = sus_warn_n;

  // Next-state decision; rail loss is checked before any sleep request.
  always_comb begin
    state_nx  = state;
    force_off = 1'b0;
    unique case (state)
      ST_G3:       if (pg_always_on) state_nx = ST_G3S5_DLY;
      ST_G3S5_DLY: if (!pg_always_on) state_nx = ST_G3;
                   else if (tmr_done) state_nx = ST_G3S5_SUS;
      ST_G3S5_SUS: if (tmr_done) state_nx = ST_S5;
      ST_S5:       if (!pg_always_on || !deep_pwr_ok) state_nx = ST_S5G3;
                   else if (s5_awake) state_nx = ST_S5S3_AO;
      ST_S5S3_AO:  if (pg_always_on) state_nx = ST_S5S3_MEM;
                   else if (tmr_done) begin force_off = 1'b1; state_nx = ST_S5; end
      ST_S5S3_MEM: if (rails_s3) state_nx = ST_S3;
                   else if (tmr_done) begin force_off = 1'b1; state_nx = ST_S5; end
      ST_S3:       if (!rails_s3) begin force_off = 1'b1; state_nx = ST_S3S5; end
                   else if (!deep_pwr_ok) state_nx = ST_S3S5;
                   else if (s3_awake) state_nx = ST_S3S0_NC;
                   else if (!s5_awake) state_nx = ST_S3S5;
      ST_S3S0_NC:  if (rails_s0) state_nx = ST_S3S0_DLY;
                   else if (tmr_done) begin force_off = 1'b1; state_nx = ST_S3; end
      ST_S3S0_DLY: if (tmr_done) state_nx = ST_S0;
      ST_S0:       if (!rails_s0) begin force_off = 1'b1; state_nx = ST_S0S3; end
                   else if (!s3_awake) state_nx = ST_S0S3;
      ST_S0S3:     if (tmr_done) state_nx = ST_S3;
      ST_S3S5:     state_nx = ST_S5;
      ST_S5G3:     state_nx = ST_G3;
      default:     state_nx = ST_G3;
    endcase
  end

  // Timer reload on every state change, with the wait of the state entered.
  always_comb begin
    tmr_load = (state_nx != state);
    unique case (state_nx)
      ST_G3S5_DLY:                          tmr_val = TW'(DSW_CYC);
      ST_G3S5_SUS:                          tmr_val = TW'(SUS_CYC);
      ST_S5S3_AO, ST_S5S3_MEM, ST_S3S0_NC:  tmr_val = TW'(RAIL_TMO);
      ST_S3S0_DLY:                          tmr_val = TW'(CORE_CYC);
      ST_S0S3:                              tmr_val = TW'(OFF_CYC);
      default:                              tmr_val = '0;
    endcase
  end

  // State register and registered outputs, updated by entry actions.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state             <= ST_G3;
      en_mem            <= 1'b0;
      en_switched       <= 1'b0;
      en_core           <= 1'b0;
      en_touchpad       <= 1'b0;
      wireless_en       <= 1'b0;
      lightbar_rst_n    <= 1'b0;
      touchscreen_rst_n <= 1'b0;
      plat_pwr_ok       <= 1'b0;
      deep_pwr_ok       <= 1'b0;
      resume_rst_n      <= 1'b0;
      cpu_throttle      <= 1'b0;
    end else begin
      state <= state_nx;
      if (state_nx != state) begin
        unique case (state_nx)
          ST_G3S5_SUS: begin deep_pwr_ok <= 1'b1; resume_rst_n <= 1'b1; end
          ST_S5S3_MEM: begin lightbar_rst_n <= 1'b1; en_mem <= 1'b1; end
          ST_S5: if (state == ST_S5S3_AO || state == ST_S5S3_MEM) begin
                   en_mem <= 1'b0; lightbar_rst_n <= 1'b0;
                 end
          ST_S3: if (state == ST_S5S3_MEM) en_touchpad <= 1'b1;
                 else if (state == ST_S3S0_NC) begin
                   touchscreen_rst_n <= 1'b0; wireless_en <= 1'b0; en_switched <= 1'b0;
                 end else begin
                   en_core <= 1'b0; wireless_en <= 1'b0;
                   cpu_throttle <= 1'b0; en_switched <= 1'b0;
                 end
          ST_S3S0_NC:  begin en_switched <= 1'b1; wireless_en <= 1'b1; touchscreen_rst_n <= 1'b1; end
          ST_S3S0_DLY: en_core <= 1'b1;
          ST_S0:       begin cpu_throttle <= throttle_req; plat_pwr_ok <= 1'b1; end
          ST_S0S3:     plat_pwr_ok <= 1'b0;
          ST_S3S5:     begin
                         en_touchpad <= 1'b0; en_mem <= 1'b0;
                         touchscreen_rst_n <= 1'b0; lightbar_rst_n <= 1'b0;
                       end
          ST_S5G3:     begin deep_pwr_ok <= 1'b0; resume_rst_n <= 1'b0; end
          default: ;
        endcase
      end else if (state == ST_S3) begin
        touchscreen_rst_n <= lid_open;
      end else if (state == ST_S0) begin
        cpu_throttle <= throttle_req;
      end
      if (force_off) begin
        deep_pwr_ok  <= 1'b0;
        resume_rst_n <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwrseq_fsm_chk.sv
module pwrseq_fsm_chk (
  input logic clk,
  input logic rst_n,
  input logic en_mem,
  input logic en_switched,
  input logic en_core,
  input logic plat_pwr_ok,
  input logic deep_pwr_ok,
  input logic resume_rst_n,
  input logic cpu_throttle,
  input logic sus_warn_n,
  input logic sus_ack_n
);
  p_pwrok_needs_core_r12: assert property (@(posedge clk) disable iff (!rst_n)
    plat_pwr_ok |-> en_core);
  p_core_needs_switched_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en_core |-> en_switched);
  p_switched_needs_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en_switched |-> en_mem);
  p_throttle_needs_switched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_throttle |-> en_switched);
  p_ack_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sus_ack_n == sus_warn_n);
  p_deep_with_resume_r2: assert property (@(posedge clk) disable iff (!rst_n)
    deep_pwr_ok == resume_rst_n);
  p_pwrok_drops_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(plat_pwr_ok) |-> en_core);
endmodule

bind pwrseq_fsm pwrseq_fsm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_mem      (en_mem),
  .en_switched (en_switched),
  .en_core     (en_core),
  .plat_pwr_ok (plat_pwr_ok),
  .deep_pwr_ok (deep_pwr_ok),
  .resume_rst_n(resume_rst_n),
  .cpu_throttle(cpu_throttle),
  .sus_warn_n  (sus_warn_n),
  .sus_ack_n   (sus_ack_n)
);

// File: tb/pwrseq_fsm_test.sv
module pwrseq_fsm_test;
  localparam int NC = 3, DSW = 12, SUS = 6, CORE = 20, OFF = 3, TMO = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_always_on = 0, pg_mem = 0, sleep_s3_n = 0, sleep_s5_n = 0;
  logic lid_open = 1, throttle_req = 0, sus_warn_n = 1;
  logic [NC-1:0] pg_noncore = '0;
  logic en_mem, en_switched, en_core, en_touchpad, wireless_en, lightbar_rst_n;
  logic touchscreen_rst_n, plat_pwr_ok, deep_pwr_ok, resume_rst_n, cpu_throttle, sus_ack_n;
  int n_checks = 0, n_err = 0;

  always #2 clk = ~clk;

  pwrseq_fsm #(.NONCORE_N(NC), .DSW_CYC(DSW), .SUS_CYC(SUS), .CORE_CYC(CORE),
               .OFF_CYC(OFF), .RAIL_TMO(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .pg_always_on(pg_always_on), .pg_mem(pg_mem),
    .pg_noncore(pg_noncore), .sleep_s3_n(sleep_s3_n), .sleep_s5_n(sleep_s5_n),
    .lid_open(lid_open), .throttle_req(throttle_req), .sus_warn_n(sus_warn_n),
    .en_mem(en_mem), .en_switched(en_switched), .en_core(en_core),
    .en_touchpad(en_touchpad), .wireless_en(wireless_en), .lightbar_rst_n(lightbar_rst_n),
    .touchscreen_rst_n(touchscreen_rst_n), .plat_pwr_ok(plat_pwr_ok),
    .deep_pwr_ok(deep_pwr_ok), .resume_rst_n(resume_rst_n),
    .cpu_throttle(cpu_throttle), .sus_ack_n(sus_ack_n));

  localparam int K_MEM = 0, K_SW = 1, K_CORE = 2, K_TP = 3, K_WL = 4, K_LB = 5,
                 K_TS = 6, K_POK = 7, K_DEEP = 8, K_RES = 9, K_HOT = 10;

  function automatic logic sig(input int k);
    case (k)
      K_MEM: return en_mem;      K_SW: return en_switched;  K_CORE: return en_core;
      K_TP: return en_touchpad;  K_WL: return wireless_en;  K_LB: return lightbar_rst_n;
      K_TS: return touchscreen_rst_n; K_POK: return plat_pwr_ok;
      K_DEEP: return deep_pwr_ok; K_RES: return resume_rst_n;
      default: return cpu_throttle;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_sig(input string req, input string what, input int k,
                          input logic v, input int lim);
    int n = 0;
    while (sig(k) !== v && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(req, what, sig(k), v);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1", "en_mem", en_mem, 0);       chk("R1", "plat_pwr_ok", plat_pwr_ok, 0);
    chk("R1", "deep_pwr_ok", deep_pwr_ok, 0); chk("R1", "resume_rst_n", resume_rst_n, 0);
    chk("R1", "touchscreen_rst_n", touchscreen_rst_n, 0); chk("R1", "cpu_throttle", cpu_throttle, 0);
  endtask

  task automatic t_g3_to_s5();
    pg_always_on = 1;
    cyc(DSW);
    chk("R2", "deep_pwr_ok not early", deep_pwr_ok, 0);
    wait_sig("R2", "deep_pwr_ok rise", K_DEEP, 1, 6);
    chk("R2", "resume_rst_n with deep", resume_rst_n, 1);
    cyc(SUS + 3);
  endtask

  task automatic t_s5_to_s3();
    sleep_s5_n = 1;
    wait_sig("R3", "lightbar release", K_LB, 1, 8);
    chk("R3", "mem enabled", en_mem, 1);
    chk("R3", "touchpad waits for mem good", en_touchpad, 0);
    pg_mem = 1;
    wait_sig("R3", "touchpad on", K_TP, 1, 4);
    lid_open = 1; cyc(2); chk("R9", "lid open", touchscreen_rst_n, 1);
    lid_open = 0; cyc(2); chk("R9", "lid closed", touchscreen_rst_n, 0);
    lid_open = 1; cyc(2); chk("R9", "lid reopened", touchscreen_rst_n, 1);
  endtask

  task automatic t_s3_to_s0(input logic thr);
    throttle_req = thr;
    sleep_s3_n = 1;
    wait_sig("R5", "switched on", K_SW, 1, 6);
    chk("R5", "wireless on", wireless_en, 1);
    chk("R5", "core waits for non-core", en_core, 0);
    chk("R10", "throttle low outside S0", cpu_throttle, 0);
    pg_noncore = '1;
    wait_sig("R5", "core on", K_CORE, 1, 4);
    cyc(CORE - 1);
    chk("R5", "pwr_ok not early", plat_pwr_ok, 0);
    wait_sig("R5", "pwr_ok rise", K_POK, 1, 5);
    chk("R10", "throttle loaded on S0 entry", cpu_throttle, thr);
    chk("R12", "nested enables in S0", en_mem & en_switched & en_core, 1);
  endtask

  task automatic t_throttle_in_s0();
    throttle_req = 0; cyc(2); chk("R10", "throttle follows low", cpu_throttle, 0);
    throttle_req = 1; cyc(2); chk("R10", "throttle follows high", cpu_throttle, 1);
  endtask

  task automatic t_s0_to_s3();
    sleep_s3_n = 0;
    wait_sig("R7", "pwr_ok drop", K_POK, 0, 5);
    chk("R7", "core still on", en_core, 1);
    wait_sig("R7", "core off", K_CORE, 0, OFF + 3);
    chk("R7", "switched off with core", en_switched, 0);
    chk("R7", "wireless off with core", wireless_en, 0);
    chk("R7", "throttle off with core", cpu_throttle, 0);
    chk("R7", "no forced shutdown", deep_pwr_ok, 1);
  endtask

  task automatic t_noncore_timeout();
    pg_noncore = '0;
    sleep_s3_n = 1;
    wait_sig("R6", "switched on", K_SW, 1, 6);
    cyc(TMO - 2);
    chk("R6", "still waiting", en_switched, 1);
    wait_sig("R6", "switched off on timeout", K_SW, 0, 6);
    chk("R6", "forced shutdown", deep_pwr_ok, 0);
    chk("R6", "touchscreen reset", touchscreen_rst_n, 0);
    chk("R6", "wireless off", wireless_en, 0);
    sleep_s3_n = 0; sleep_s5_n = 0;
    wait_sig("R8", "walk down turns mem off", K_MEM, 0, 8);
    wait_sig("R2", "repower deep_pwr_ok", K_DEEP, 1, DSW + 20);
    cyc(SUS + 3);
  endtask

  task automatic t_priority();
    sleep_s5_n = 1;
    wait_sig("R3", "touchpad on again", K_TP, 1, 12);
    sleep_s3_n = 1; pg_noncore = '1;
    wait_sig("R5", "pwr_ok again", K_POK, 1, CORE + 20);
    sleep_s3_n = 0;
    cyc(2);
    pg_noncore[NC-1] = 0;
    cyc(1);
    chk("R8", "pwr_ok dropped", plat_pwr_ok, 0);
    chk("R8", "rail loss wins, forced", deep_pwr_ok, 0);
    sleep_s5_n = 0; pg_mem = 0;
    wait_sig("R8", "walk to G3 mem off", K_MEM, 0, OFF + 12);
    wait_sig("R2", "repower after walk", K_DEEP, 1, DSW + 20);
    cyc(SUS + 3);
  endtask

  task automatic t_mem_timeout();
    sleep_s5_n = 1;
    wait_sig("R4", "mem enabled", K_MEM, 1, 8);
    wait_sig("R4", "mem off on timeout", K_MEM, 0, TMO + 4);
    chk("R4", "forced shutdown", deep_pwr_ok, 0);
    chk("R4", "lightbar reset", lightbar_rst_n, 0);
    sleep_s5_n = 0;
    wait_sig("R2", "repower after timeout", K_DEEP, 1, DSW + 20);
    cyc(SUS + 3);
  endtask

  task automatic t_always_on_loss();
    pg_always_on = 0;
    wait_sig("R13", "deep drop", K_DEEP, 0, 4);
    chk("R13", "resume reset asserted", resume_rst_n, 0);
  endtask

  task automatic t_sus_ack();
    sus_warn_n = 0; #1 chk("R11", "ack low", sus_ack_n, 0);
    sus_warn_n = 1; #1 chk("R11", "ack high", sus_ack_n, 1);
  endtask

  initial begin
    cyc(4);
    rst_n = 1;
    t_reset();
    t_g3_to_s5();
    t_s5_to_s3();
    t_sus_ack();
    t_s3_to_s0(1'b1);
    t_throttle_in_s0();
    t_s0_to_s3();
    t_noncore_timeout();
    t_priority();
    t_mem_timeout();
    t_always_on_loss();
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule